// File: doc/BRIEF.md
# Device Interrupt Routing Controller

This block sits between a fixed set of device interrupt sources and the processors. For each source it keeps a route (the target CPU number and the interrupt vector) and a gate (a mask bit and a pending bit). A source that fires while unmasked is accepted. Accepting it masks the source, marks it pending and sends a single-cycle post carrying the routed CPU and vector. A source that fires while masked is dropped without trace.

Because the mask is set on acceptance, software must write the gate again to open the source before it can fire a second time. Software also clears the pending flag through a dedicated clear bit in the same register. The register port is 64 bits wide and has two banks, a route bank and a gate bank. Each bank holds one entry per source on an 8-byte stride. The index is the offset from the bank base shifted right by three, so the low three address bits are ignored.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every gate has mask = 1 and pending = 0, every route reads zero, and post_valid_o is low.
- R2: A route write stores wdata[12:8] as the CPU and wdata[5:0] as the vector. A route read returns them in the same bit positions, with all other bits zero.
- R3: A gate read returns the mask in bit 2 and pending in bit 0, each reflecting its own state, with all other bits zero.
- R4: A gate write loads the mask from wdata[2]. wdata[1] = 1 clears pending. wdata[0] has no effect on pending.
- R5: An interrupt (irq_valid_i with irq_src_i) from a masked source produces no post and changes no mask or pending bit.
- R6: An interrupt from an unmasked source sets its mask and pending. In the next cycle, post_valid_o is high for exactly one cycle, with post_cpu_o and post_vec_o holding that source's route as it stood before the interrupt.
- R7: After acceptance, further interrupts from that source are dropped until software clears its mask.
- R8: The route bank starts at offset 0x000 and the gate bank at 0x100, each with N_SRC entries. Entry index = (offset - bank base) >> 3, and address bits 2:0 are ignored.
- R9: If a gate write and an accepted interrupt hit the same source in the same cycle, the interrupt wins: mask and pending both end set.
- R10: An access to an offset outside both banks raises reg_err_o, returns zero on a read and changes no state on a write. Decoded accesses leave reg_err_o low.
- R11: reg_rdata_o and reg_err_o are registered. They carry the response in the cycle after the request and are zero in any cycle that follows a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Byte offset of the access |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data, one cycle after the request |
| reg_err_o | output | 1 | Undecoded-offset flag, one cycle after the request |
| irq_valid_i | input | 1 | Device interrupt strobe |
| irq_src_i | input | IDX_W | Index of the interrupting source |
| post_valid_o | output | 1 | Post request to a CPU |
| post_cpu_o | output | 5 | Target CPU of the post |
| post_vec_o | output | 6 | Vector of the post |

## Verification
The assertions assume that irq_src_i names an existing source whenever irq_valid_i is high, and that at most one interrupt is offered per cycle, since the port carries a single index. The bench only raises interrupts on source numbers from 0 to N_SRC-1. It drives every input on the falling clock edge and samples on the falling edge that follows the capturing rising edge. The collision case is created on purpose by driving a gate write and an interrupt for the same source in one cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int REG_DW   = 64;
  localparam int CPU_W    = 5;
  localparam int VEC_W    = 6;
  localparam int CPU_LSB  = 8;
  localparam int VEC_LSB  = 0;
  localparam int MASK_POS = 2;
  localparam int CLR_POS  = 1;
  localparam int PEND_POS = 0;

  typedef struct packed {
    logic [CPU_W-1:0] cpu;
    logic [VEC_W-1:0] vec;
  } route_t;

  typedef enum logic [1:0] {
    BANK_NONE  = 2'd0,
    BANK_ROUTE = 2'd1,
    BANK_GATE  = 2'd2
  } bank_e;

  function automatic logic [REG_DW-1:0] pack_route(route_t r);
    logic [REG_DW-1:0] d;
    d = '0;
    d[CPU_LSB +: CPU_W] = r.cpu;
    d[VEC_LSB +: VEC_W] = r.vec;
    return d;
  endfunction

  function automatic route_t unpack_route(logic [REG_DW-1:0] d);
    route_t r;
    r.cpu = d[CPU_LSB +: CPU_W];
    r.vec = d[VEC_LSB +: VEC_W];
    return r;
  endfunction

  function automatic logic [REG_DW-1:0] pack_gate(logic mask, logic pend);
    logic [REG_DW-1:0] d;
    d = '0;
    d[MASK_POS] = mask;
    d[PEND_POS] = pend;
    return d;
  endfunction
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int N_SRC   = 16,
  parameter int ADDR_W  = 12,
  parameter int RT_BASE = 'h000,
  parameter int GT_BASE = 'h100,
  parameter int IDX_W   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output bank_e             bank_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] RT_BASE_A = ADDR_W'(RT_BASE);
  localparam logic [ADDR_W-1:0] GT_BASE_A = ADDR_W'(GT_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A    = ADDR_W'(N_SRC * 8);

  logic [ADDR_W-1:0] rt_off, gt_off;

  // below-base offsets wrap high and fall outside the span
  assign rt_off = addr_i - RT_BASE_A;
  assign gt_off = addr_i - GT_BASE_A;

  always_comb begin
    bank_o = BANK_NONE;
    idx_o  = '0;
    if (rt_off < SPAN_A) begin
      bank_o = BANK_ROUTE;
      idx_o  = rt_off[IDX_W+2:3];
    end else if (gt_off < SPAN_A) begin
      bank_o = BANK_GATE;
      idx_o  = gt_off[IDX_W+2:3];
    end
  end

  always_comb begin
    if (bank_o != BANK_NONE)
      assert_idx_in_bank_R8: assert (32'(idx_o) < N_SRC);
  end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_route_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  route_t           wroute_i,
  output route_t           route_o [N_SRC]
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_entry
    route_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ent_q <= '0;
      else if (we_i && widx_i == IDX_W'(i))         ent_q <= wroute_i;
    end
    assign route_o[i] = ent_q;

    assert_route_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && widx_i == IDX_W'(i)) |=> (ent_q == $past(wroute_i)));
  end
endmodule

// File: rtl/irq_route_gate.sv
module irq_route_gate #(
  parameter int N_SRC = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic             wmask_i,
  input  logic             wclr_i,
  input  logic             irq_valid_i,
  input  logic [IDX_W-1:0] irq_src_i,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] pend_o,
  output logic             accept_o
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_gate
    logic sel_w, mask_q, pend_q;
    assign hit[i] = irq_valid_i && irq_src_i == IDX_W'(i) && !mask_q;
    assign sel_w  = we_i && widx_i == IDX_W'(i);

    // acceptance overrides a same-cycle software write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q <= 1'b1;
        pend_q <= 1'b0;
      end else if (hit[i]) begin
        mask_q <= 1'b1;
        pend_q <= 1'b1;
      end else if (sel_w) begin
        mask_q <= wmask_i;
        if (wclr_i) pend_q <= 1'b0;
      end
    end
    assign mask_o[i] = mask_q;
    assign pend_o[i] = pend_q;
  end

  assign accept_o = |hit;

  assert_src_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_i |-> (32'(irq_src_i) < N_SRC));

  assert_accept_marks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (mask_o[$past(irq_src_i)] && pend_o[$past(irq_src_i)]));

  assert_masked_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_i && mask_o[irq_src_i] && !we_i) |=> ($stable(mask_o) && $stable(pend_o)));

  assert_accept_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !we_i) |=> !(irq_valid_i && irq_src_i == $past(irq_src_i) && accept_o));

  assert_collision_win_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && we_i && widx_i == irq_src_i && !wmask_i) |=> mask_o[$past(widx_i)]);
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int N_SRC   = 16,
  parameter int ADDR_W  = 12,
  parameter int RT_BASE = 'h000,
  parameter int GT_BASE = 'h100,
  localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic              reg_err_o,
  input  logic              irq_valid_i,
  input  logic [IDX_W-1:0]  irq_src_i,
  output logic              post_valid_o,
  output logic [4:0]        post_cpu_o,
  output logic [5:0]        post_vec_o
);
  bank_e            bank;
  logic [IDX_W-1:0] idx;
  logic             rt_we, gt_we, accept;
  route_t           routes [N_SRC];
  logic [N_SRC-1:0] mask, pend;
  logic [63:0]      rd_mux, rdata_q;
  logic             err_q, post_q;
  route_t           post_r_q;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  irq_route_decode #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W), .RT_BASE(RT_BASE), .GT_BASE(GT_BASE), .IDX_W(IDX_W)
  ) i_decode (
    .addr_i(reg_addr_i), .bank_o(bank), .idx_o(idx)
  );

  assign rt_we = reg_req_i && reg_we_i && bank == BANK_ROUTE;
  assign gt_we = reg_req_i && reg_we_i && bank == BANK_GATE;

  irq_route_table #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_table (
    .clk_i, .rst_ni,
    .we_i(rt_we), .widx_i(idx), .wroute_i(unpack_route(reg_wdata_i)),
    .route_o(routes)
  );

  irq_route_gate #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_gate (
    .clk_i, .rst_ni,
    .we_i(gt_we), .widx_i(idx),
    .wmask_i(reg_wdata_i[MASK_POS]), .wclr_i(reg_wdata_i[CLR_POS]),
    .irq_valid_i, .irq_src_i,
    .mask_o(mask), .pend_o(pend), .accept_o(accept)
  );

  always_comb begin
    unique case (bank)
      BANK_ROUTE: rd_mux = pack_route(routes[idx]);
      BANK_GATE:  rd_mux = pack_gate(mask[idx], pend[idx]);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      err_q    <= 1'b0;
      post_q   <= 1'b0;
      post_r_q <= '0;
    end else begin
      rdata_q  <= (reg_req_i && !reg_we_i) ? rd_mux : '0;
      err_q    <= reg_req_i && bank == BANK_NONE;
      post_q   <= accept;
      post_r_q <= accept ? routes[irq_src_i] : '0;
    end
  end

  assign reg_rdata_o  = rdata_q;
  assign reg_err_o    = err_q;
  assign post_valid_o = post_q;
  assign post_cpu_o   = post_r_q.cpu;
  assign post_vec_o   = post_r_q.vec;

  assert_idle_resp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_req_i |=> (reg_rdata_o == '0 && !reg_err_o));

  assert_err_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_err_o |-> (reg_rdata_o == '0));

  assert_post_needs_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_i |=> !post_valid_o);

  assert_route_rsvd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && bank == BANK_ROUTE) |=>
      (reg_rdata_o[63:13] == '0 && reg_rdata_o[7:6] == '0));

  assert_gate_rsvd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && bank == BANK_GATE) |=>
      (reg_rdata_o[63:3] == '0 && !reg_rdata_o[1]));
endmodule

// File: tb/test_irq_route_ctrl.sv
module test_irq_route_ctrl;
  localparam int IDX_W = 4;
  localparam logic [11:0] GT = 12'h100;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0, irq_v = 0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic [IDX_W-1:0] irq_s = '0;
  logic        err, pv;
  logic [4:0]  pcpu;
  logic [5:0]  pvec;
  int n_chk = 0, n_err = 0;

  always #10ns clk = ~clk;

  irq_route_ctrl i_irq_route_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .reg_err_o(err),
    .irq_valid_i(irq_v), .irq_src_i(irq_s),
    .post_valid_o(pv), .post_cpu_o(pcpu), .post_vec_o(pvec)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d, output logic e);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata; e = err;
  endtask

  task automatic rd_chk(input string r, input logic [11:0] a, input logic [63:0] exp);
    logic [63:0] d; logic e;
    rd(a, d, e);
    chk(r, d, exp);
  endtask

  // fire an interrupt and check the post and its one-cycle width
  task automatic fire(input string r, input int s, input logic v, input logic [4:0] c,
                      input logic [5:0] vec);
    @(negedge clk); irq_v = 1; irq_s = IDX_W'(s);
    @(negedge clk); irq_v = 0;
    chk(r, {63'd0, pv}, {63'd0, v});
    if (v) begin
      chk(r, {59'd0, pcpu}, {59'd0, c});
      chk(r, {58'd0, pvec}, {58'd0, vec});
    end
    @(negedge clk);
    chk(r, {63'd0, pv}, 64'd0);
  endtask

  task automatic t_reset;
    chk("R1", {63'd0, pv}, 64'd0);
    rd_chk("R1", 12'h000, 64'd0);
    rd_chk("R1", 12'h078, 64'd0);
    rd_chk("R1", GT + 12'h000, 64'h4);
    rd_chk("R1", GT + 12'h078, 64'h4);
  endtask

  task automatic t_route;
    wr(12'h018, '1);
    rd_chk("R2", 12'h018, 64'h1F3F);
    wr(12'h028, 64'hFFFF_0000_0000_072A);
    rd_chk("R8", 12'h02D, 64'h072A);
    rd_chk("R8", 12'h020, 64'd0);
  endtask

  task automatic t_masked;
    fire("R5", 2, 0, 0, 0);
    rd_chk("R5", GT + 12'h010, 64'h4);
  endtask

  task automatic t_accept;
    wr(GT + 12'h028, 64'd0);
    rd_chk("R4", GT + 12'h028, 64'd0);
    fire("R6", 5, 1, 5'h07, 6'h2A);
    rd_chk("R3", GT + 12'h028, 64'h5);
    fire("R7", 5, 0, 0, 0);
    rd_chk("R7", GT + 12'h028, 64'h5);
  endtask

  task automatic t_gate_write;
    wr(GT + 12'h028, 64'h1);
    rd_chk("R4", GT + 12'h028, 64'h1);
    wr(GT + 12'h028, 64'h2);
    rd_chk("R4", GT + 12'h028, 64'h0);
    wr(GT + 12'h028, 64'h6);
    rd_chk("R4", GT + 12'h028, 64'h4);
  endtask

  task automatic t_edges;
    wr(12'h078, 64'h1E01);
    wr(GT + 12'h078, 64'd0);
    fire("R6", 15, 1, 5'h1E, 6'h01);
    wr(12'h000, 64'h0100);
    wr(GT + 12'h000, 64'd0);
    fire("R6", 0, 1, 5'h01, 6'h00);
  endtask

  task automatic t_collide;
    wr(12'h030, 64'h0311);
    wr(GT + 12'h030, 64'd0);
    @(negedge clk);
    req = 1; we = 1; addr = GT + 12'h030; wdata = 64'h2;
    irq_v = 1; irq_s = IDX_W'(6);
    @(negedge clk);
    req = 0; we = 0; irq_v = 0;
    chk("R9", {63'd0, pv}, 64'd1);
    chk("R9", {53'd0, pcpu, pvec}, 64'h0D1);
    rd_chk("R9", GT + 12'h030, 64'h5);
  endtask

  task automatic t_undecoded;
    logic [63:0] d; logic e;
    rd(12'h080, d, e);
    chk("R10", {63'd0, e}, 64'd1); chk("R10", d, 64'd0);
    rd(12'h180, d, e);
    chk("R10", {63'd0, e}, 64'd1); chk("R10", d, 64'd0);
    wr(12'h180, '1);
    chk("R10", {63'd0, err}, 64'd1);
    wr(12'h0F8, 64'h0);
    chk("R10", {63'd0, err}, 64'd1);
    rd(GT + 12'h078, d, e);
    chk("R10", {63'd0, e}, 64'd0); chk("R10", d, 64'h5);
    rd_chk("R10", 12'h078, 64'h1E01);
  endtask

  task automatic t_idle;
    logic [63:0] d; logic e;
    rd(12'h078, d, e);
    chk("R11", d, 64'h1E01);
    @(negedge clk);
    chk("R11", rdata, 64'd0);
    chk("R11", {63'd0, err}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route();
    t_masked();
    t_accept();
    t_gate_write();
    t_edges();
    t_collide();
    t_undecoded();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule